// File: doc/BRIEF.md
# Latency-Based Pipeline Interlock Unit

This unit sits at the issue point of a single-issue, in-order pipeline. Each cycle it looks at the instruction offered for issue: its class, its destination and its two source registers. It decides whether that instruction can go now or must wait for an older result. The wait does not come from a single fixed delay. It depends on which class produced the value and on how the new instruction uses it. An FP result feeding another FP operation needs a longer gap than the same result feeding the data port of a store.

A scoreboard keeps one entry per architectural register. Each entry holds a countdown and the class of the newest instruction that writes that register. The countdown is loaded at issue and falls by one every clock edge, whether the cycle issued, stalled or was idle. A consumer is held back until enough cycles lie between it and its producer.

Functional units are assumed fully pipelined, so resources never cause a stall. The slot after a branch is the branch delay slot, and the instruction in it always issues.

Top module: `ilk_interlock`

## Requirements
- R1: A source used as an FP operand, produced by an FP-class instruction, waits until 3 cycles separate the two. Issued back to back, the consumer stalls 3 cycles. Class codes: 0 FP op, 1 load, 2 store, 3 integer, 4 branch.
- R2: The data source of a store (source b) produced by an FP-class instruction needs 2 separating cycles.
- R3: An FP operand produced by a load needs 1 separating cycle.
- R4: Store data produced by a load needs no separating cycle, so there is no stall.
- R5: A branch operand produced by an integer instruction needs 1 separating cycle. An integer operand produced by an integer instruction needs none.
- R6: Stall cycles equal the required gap minus the cycles already elapsed since the producer issued, and never go below zero. Idle cycles and stall cycles both count as elapsed.
- R7: The first instruction offered after a branch issues at once, whatever its hazards. The instruction after that one is checked normally.
- R8: stall is high only while in_valid is high and a hazard exists. issue is high exactly when in_valid is high and stall is low, so no issue strobe appears in a stall cycle.
- R9: Source a of a load or store is an address (integer role), so an FP or load producer adds no wait for it. Source b of a load is ignored.
- R10: Only FP, load and integer instructions write their destination. A store, a branch or an undefined class code (5 to 7) writes nothing, and an undefined class reads nothing.
- R11: When a register is written again, the newest writer's class and issue time decide the wait.
- R12: After reset no register is pending, and an instruction offered at once issues without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered for issue |
| in_class | input | 3 | Instruction class code |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| stall | output | 1 | Offered instruction must wait |
| issue | output | 1 | Offered instruction issues this cycle |

## Verification
Producer and consumer pairs are issued back to back, one pair for each entry of the latency matrix. This separates the four non-zero gaps from the zero ones, and the FP operand role from the store-data role. Other sequences insert independent instructions or idle cycles between a producer and its consumer. They show that the countdown is driven by elapsed cycles and not by issued instructions. Further sequences place a hazard in a branch delay slot and then the same hazard right after it, exercise address operands and non-writing classes, and rewrite a register. Together these separate a one-shot slot exemption from a permanent one, and newest-writer tracking from oldest-writer tracking.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   typedef enum logic [2:0] {
      CLS_FP  = 3'd0,
      CLS_LD  = 3'd1,
      CLS_ST  = 3'd2,
      CLS_INT = 3'd3,
      CLS_BR  = 3'd4
   } op_class_e;

   typedef enum logic [1:0] {
      ROLE_FP  = 2'd0,
      ROLE_STD = 2'd1,
      ROLE_INT = 2'd2,
      ROLE_BR  = 2'd3
   } role_e;

   function automatic int unsigned imax(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction
endpackage

// File: rtl/ilk_lat_entry.sv
module ilk_lat_entry
   import ilk_pkg::*;
#(
   parameter int unsigned LAT_FP_FP   = 3,
   parameter int unsigned LAT_FP_ST   = 2,
   parameter int unsigned LAT_LD_FP   = 1,
   parameter int unsigned LAT_LD_ST   = 0,
   parameter int unsigned LAT_INT_BR  = 1,
   parameter int unsigned LAT_INT_INT = 0,
   parameter int unsigned CW          = 2
) (
   input  op_class_e         prod,
   input  role_e             role,
   output logic [CW-1:0]     need,
   output logic [CW-1:0]     horizon
);
   localparam int unsigned HZ_FP  = imax(LAT_FP_FP, LAT_FP_ST);
   localparam int unsigned HZ_LD  = imax(LAT_LD_FP, LAT_LD_ST);
   localparam int unsigned HZ_INT = imax(LAT_INT_BR, LAT_INT_INT);

   always_comb begin
      need    = '0;
      horizon = '0;
      case (prod)
         CLS_FP: begin
            horizon = CW'(HZ_FP);
            if (role == ROLE_FP)       need = CW'(LAT_FP_FP);
            else if (role == ROLE_STD) need = CW'(LAT_FP_ST);
         end
         CLS_LD: begin
            horizon = CW'(HZ_LD);
            if (role == ROLE_FP)       need = CW'(LAT_LD_FP);
            else if (role == ROLE_STD) need = CW'(LAT_LD_ST);
         end
         CLS_INT: begin
            horizon = CW'(HZ_INT);
            if (role == ROLE_BR)       need = CW'(LAT_INT_BR);
            else if (role == ROLE_INT) need = CW'(LAT_INT_INT);
         end
         default: begin
            horizon = '0;
            need    = '0;
         end
      endcase
   end
endmodule

// File: rtl/ilk_score.sv
module ilk_score
   import ilk_pkg::*;
#(
   parameter int unsigned NREG = 32,
   parameter int unsigned CW   = 2,
   localparam int unsigned RW  = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RW-1:0]    wr_idx,
   input  logic [CW-1:0]    wr_cnt,
   input  op_class_e        wr_cls,
   input  logic [RW-1:0]    rd_idx [2],
   output logic [CW-1:0]    rd_cnt [2],
   output op_class_e        rd_cls [2]
);
   logic [NREG-1:0][CW-1:0] cnt_all;
   logic [NREG-1:0][2:0]    cls_all;

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      logic [CW-1:0] c_q;
      op_class_e     k_q;
      logic          hit_w;

      assign hit_w = wr_en && (wr_idx == RW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= '0;
            k_q <= CLS_INT;
         end else if (hit_w) begin
            c_q <= wr_cnt;
            k_q <= wr_cls;
         end else if (c_q != '0) begin
            c_q <= c_q - CW'(1);
         end
      end

      assign cnt_all[i] = c_q;
      assign cls_all[i] = k_q;

      a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
         (c_q != '0 && !hit_w) |=> (c_q == $past(c_q) - CW'(1)));

      a_r12_reset_clear: assert property (@(posedge clk)
         !rst_n |=> (c_q == '0));
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      assign rd_cnt[p] = cnt_all[rd_idx[p]];
      assign rd_cls[p] = op_class_e'(cls_all[rd_idx[p]]);
   end
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
   import ilk_pkg::*;
#(
   parameter int unsigned LAT_FP_FP   = 3,
   parameter int unsigned LAT_FP_ST   = 2,
   parameter int unsigned LAT_LD_FP   = 1,
   parameter int unsigned LAT_LD_ST   = 0,
   parameter int unsigned LAT_INT_BR  = 1,
   parameter int unsigned LAT_INT_INT = 0,
   parameter int unsigned CW          = 2
) (
   input  logic          active,
   input  op_class_e     prod,
   input  logic [CW-1:0] left,
   input  role_e         role,
   output logic          hit
);
   logic [CW-1:0] need;
   logic [CW-1:0] horizon;

   ilk_lat_entry #(
      .LAT_FP_FP(LAT_FP_FP), .LAT_FP_ST(LAT_FP_ST),
      .LAT_LD_FP(LAT_LD_FP), .LAT_LD_ST(LAT_LD_ST),
      .LAT_INT_BR(LAT_INT_BR), .LAT_INT_INT(LAT_INT_INT),
      .CW(CW)
   ) u_lat (
      .prod(prod), .role(role), .need(need), .horizon(horizon)
   );

   // left counts down from horizon; elapsed gap = horizon - left
   assign hit = active && (left != '0) && (left > (horizon - need));
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
   import ilk_pkg::*;
#(
   parameter int unsigned NREG        = 32,
   parameter int unsigned LAT_FP_FP   = 3,
   parameter int unsigned LAT_FP_ST   = 2,
   parameter int unsigned LAT_LD_FP   = 1,
   parameter int unsigned LAT_LD_ST   = 0,
   parameter int unsigned LAT_INT_BR  = 1,
   parameter int unsigned LAT_INT_INT = 0,
   localparam int unsigned RW         = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [2:0]    in_class,
   input  logic [RW-1:0] in_dst,
   input  logic [RW-1:0] in_src_a,
   input  logic [RW-1:0] in_src_b,
   output logic          stall,
   output logic          issue
);
   localparam int unsigned MAXLAT = imax(imax(imax(LAT_FP_FP, LAT_FP_ST), imax(LAT_LD_FP, LAT_LD_ST)),
                                         imax(LAT_INT_BR, LAT_INT_INT));
   localparam int unsigned CW     = (MAXLAT < 1) ? 1 : $clog2(MAXLAT + 1);

   if (NREG < 2) begin : g_bad_nreg
      $error("ilk_interlock: NREG must be at least 2");
   end
   if ((1 << RW) != NREG) begin : g_bad_pow2
      $error("ilk_interlock: NREG must be a power of two");
   end

   op_class_e     cls;
   logic          writes;
   logic          act   [2];
   role_e         role  [2];
   logic [RW-1:0] src   [2];
   logic [CW-1:0] left  [2];
   op_class_e     prod  [2];
   logic          hit   [2];
   logic [CW-1:0] wr_need_unused;
   logic [CW-1:0] wr_horizon;
   logic          slot_q;

   assign cls    = op_class_e'(in_class);
   assign src[0] = in_src_a;
   assign src[1] = in_src_b;

   always_comb begin
      writes  = 1'b0;
      act[0]  = 1'b0;
      act[1]  = 1'b0;
      role[0] = ROLE_INT;
      role[1] = ROLE_INT;
      case (cls)
         CLS_FP: begin
            writes = 1'b1; act[0] = 1'b1; act[1] = 1'b1;
            role[0] = ROLE_FP; role[1] = ROLE_FP;
         end
         CLS_LD: begin
            writes = 1'b1; act[0] = 1'b1;
         end
         CLS_ST: begin
            act[0] = 1'b1; act[1] = 1'b1; role[1] = ROLE_STD;
         end
         CLS_INT: begin
            writes = 1'b1; act[0] = 1'b1; act[1] = 1'b1;
         end
         CLS_BR: begin
            act[0] = 1'b1; act[1] = 1'b1;
            role[0] = ROLE_BR; role[1] = ROLE_BR;
         end
         default: begin
            writes = 1'b0;
         end
      endcase
   end

   ilk_score #(.NREG(NREG), .CW(CW)) u_score (
      .clk(clk), .rst_n(rst_n),
      .wr_en(issue && writes), .wr_idx(in_dst),
      .wr_cnt(wr_horizon), .wr_cls(cls),
      .rd_idx(src), .rd_cnt(left), .rd_cls(prod)
   );

   ilk_lat_entry #(
      .LAT_FP_FP(LAT_FP_FP), .LAT_FP_ST(LAT_FP_ST),
      .LAT_LD_FP(LAT_LD_FP), .LAT_LD_ST(LAT_LD_ST),
      .LAT_INT_BR(LAT_INT_BR), .LAT_INT_INT(LAT_INT_INT),
      .CW(CW)
   ) u_wr_lat (
      .prod(cls), .role(ROLE_INT), .need(wr_need_unused), .horizon(wr_horizon)
   );

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      ilk_hazard #(
         .LAT_FP_FP(LAT_FP_FP), .LAT_FP_ST(LAT_FP_ST),
         .LAT_LD_FP(LAT_LD_FP), .LAT_LD_ST(LAT_LD_ST),
         .LAT_INT_BR(LAT_INT_BR), .LAT_INT_INT(LAT_INT_INT),
         .CW(CW)
      ) u_hz (
         .active(act[g]), .prod(prod[g]), .left(left[g]),
         .role(role[g]), .hit(hit[g])
      );
   end

   // Delay slot: armed by an issued branch, consumed by the next issue.
   always_ff @(posedge clk) begin
      if (!rst_n)     slot_q <= 1'b0;
      else if (issue) slot_q <= (cls == CLS_BR);
   end

   assign stall = in_valid && (hit[0] || hit[1]) && !slot_q;
   assign issue = in_valid && !stall;

   a_r1_fp_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue && cls == CLS_FP) && in_valid && cls == CLS_FP
       && in_src_a == $past(in_dst) && $past(cls) != CLS_BR) |-> stall);

   a_r7_slot_issues: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue && cls == CLS_BR) && in_valid) |-> issue);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!stall && !issue));

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall && issue));

   a_r8_held_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (in_valid && $stable(in_class) && $stable(in_src_a) && $stable(in_src_b)));
endmodule

// File: tb/tb_ilk_interlock.sv
module tb_ilk_interlock;
   localparam int PERIOD = 10;
   localparam int HALF   = PERIOD / 2;
   localparam int RWB    = 5;

   localparam logic [2:0] C_FP = 3'd0, C_LD = 3'd1, C_ST = 3'd2, C_INT = 3'd3, C_BR = 3'd4, C_UND = 3'd5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [2:0]     in_class = 3'd0;
   logic [RWB-1:0] in_dst = '0;
   logic [RWB-1:0] in_src_a = '0;
   logic [RWB-1:0] in_src_b = '0;
   logic           stall;
   logic           issue;

   typedef struct { int exp; string tag; } item_t;
   item_t q[$];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(HALF) clk = ~clk;

   ilk_interlock dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .stall(stall), .issue(issue)
   );

   task automatic report();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Driver: called at a falling edge, returns at the falling edge after issue.
   task automatic send(input logic [2:0] c, input int d, input int a, input int b,
                       input int exp, input string tag);
      item_t it;
      it.exp = exp;
      it.tag = tag;
      q.push_back(it);
      in_valid = 1'b1;
      in_class = c;
      in_dst   = RWB'(d);
      in_src_a = RWB'(a);
      in_src_b = RWB'(b);
      forever begin
         #(HALF - 1);
         if (issue) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n, input string tag);
      in_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         #(HALF - 1);
         n_chk++;
         if (stall || issue) begin
            n_fail++;
            $display("FAIL %s idle: stall=%0b issue=%0b expected 0 0", tag, stall, issue);
         end
         @(negedge clk);
      end
   endtask

   // Monitor: counts stall cycles per offered instruction, compares at issue.
   initial begin
      int scnt = 0;
      forever begin
         @(negedge clk);
         #(HALF - 1);
         if (rst_n && in_valid) begin
            if (stall && issue) begin
               n_chk++; n_fail++;
               $display("FAIL R8: stall=1 issue=1 expected exclusive");
            end else if (stall) begin
               scnt++;
            end else if (issue) begin
               item_t it;
               n_chk++;
               if (q.size() == 0) begin
                  n_fail++;
                  $display("FAIL R8: unexpected issue, actual 1 expected 0");
               end else begin
                  it = q.pop_front();
                  if (scnt != it.exp) begin
                     n_fail++;
                     $display("FAIL %s: stall cycles actual %0d expected %0d", it.tag, scnt, it.exp);
                  end
               end
               scnt = 0;
            end else begin
               n_chk++; n_fail++;
               $display("FAIL R8: valid with neither stall nor issue");
            end
         end
      end
   end

   initial begin
      #(PERIOD * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      #(HALF - 1);
      n_chk++;
      if (stall || issue) begin
         n_fail++;
         $display("FAIL R12 reset: stall=%0b issue=%0b expected 0 0", stall, issue);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R12: fresh scoreboard, reading any register issues at once
      send(C_FP, 1, 9, 10, 0, "R12 after reset");
      idle(4, "R8");
      // R1
      send(C_FP, 1, 2, 3, 0, "R1 producer");
      send(C_FP, 4, 1, 0, 3, "R1 fp->fp src a");
      idle(4, "R8");
      send(C_FP, 23, 2, 3, 0, "R1 producer b");
      send(C_FP, 24, 0, 23, 3, "R1 fp->fp src b");
      idle(4, "R8");
      // R2
      send(C_FP, 2, 0, 0, 0, "R2 producer");
      send(C_ST, 0, 0, 2, 2, "R2 fp->store data");
      idle(4, "R8");
      // R3
      send(C_LD, 3, 0, 0, 0, "R3 producer");
      send(C_FP, 5, 3, 0, 1, "R3 load->fp");
      idle(4, "R8");
      // R4
      send(C_LD, 4, 0, 0, 0, "R4 producer");
      send(C_ST, 0, 0, 4, 0, "R4 load->store data");
      idle(4, "R8");
      // R5
      send(C_INT, 5, 0, 0, 0, "R5 producer");
      send(C_BR, 0, 5, 0, 1, "R5 int->branch");
      send(C_INT, 7, 0, 0, 0, "R5 delay slot filler");
      send(C_INT, 8, 7, 0, 0, "R5 int->int");
      idle(4, "R8");
      // R7: hazard in the slot is forced; next one is checked again
      send(C_FP, 6, 0, 0, 0, "R7 producer");
      send(C_BR, 0, 0, 0, 0, "R7 branch");
      send(C_FP, 8, 6, 0, 0, "R7 slot forced");
      send(C_FP, 9, 6, 0, 1, "R7 after slot");
      idle(4, "R8");
      // R6: gap by an independent instruction and by idle cycles
      send(C_FP, 10, 0, 0, 0, "R6 producer");
      send(C_INT, 11, 0, 0, 0, "R6 independent");
      send(C_FP, 12, 10, 0, 2, "R6 one gap");
      idle(4, "R8");
      send(C_FP, 12, 0, 0, 0, "R6 producer idle");
      idle(2, "R6 idle");
      send(C_FP, 13, 12, 0, 1, "R6 idle gap");
      idle(4, "R8");
      // R9
      send(C_FP, 13, 0, 0, 0, "R9 producer");
      send(C_ST, 0, 13, 0, 0, "R9 store address");
      idle(4, "R8");
      send(C_FP, 15, 0, 0, 0, "R9 producer b");
      send(C_LD, 16, 0, 15, 0, "R9 load src b ignored");
      idle(4, "R8");
      // R10
      send(C_ST, 18, 0, 0, 0, "R10 store no write");
      send(C_FP, 19, 18, 0, 0, "R10 read after store");
      idle(4, "R8");
      send(C_UND, 20, 0, 0, 0, "R10 undefined no write");
      send(C_FP, 21, 20, 0, 0, "R10 read after undefined");
      send(C_UND, 25, 21, 21, 0, "R10 undefined reads nothing");
      idle(4, "R8");
      // R11
      send(C_FP, 22, 0, 0, 0, "R11 old writer");
      send(C_LD, 22, 0, 0, 0, "R11 new writer");
      send(C_FP, 26, 22, 0, 1, "R11 newest decides");
      idle(4, "R8");
      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R8: pending items actual %0d expected 0", q.size());
      end
      report();
   end
endmodule